// File: doc/BRIEF.md
# Integer Multiply and Divide Execution Unit

This execution unit takes only the integer multiply and divide operations of a superscalar core. Every other integer operation runs in single-cycle units elsewhere. Multiplies go through a pipeline of fixed depth that can take a new operation every cycle. Divides use one sequential engine that holds a single operation at a time. Each operation enters with two 32-bit operands and a destination tag. Its result leaves on one shared result port, carrying the same tag, so the issuing logic can match it to the waiting consumer.

The issuer presents an operation together with `issue_valid`. The operation is taken on a clock edge at which `issue_ready` is high. `issue_ready` depends on the operation being offered. A divide offer is refused while the divide engine is occupied. A multiply offer is refused only in the cycle in which the multiply pipeline is frozen. Both latencies are parameters. When the divide engine and the multiply pipeline both have a result due in the same cycle, the divide result takes the port. The whole multiply pipeline then holds for one cycle.

Top module: `mdu_unit`

## Requirements
- R1: A multiply returns the low 32 bits of the two's-complement product of the two operands, read as signed values.
- R2: When no collision occurs, a multiply taken in cycle N produces its result with `res_valid` high in cycle N+MUL_LAT.
- R3: The multiply pipeline takes one operation in every cycle of a back-to-back stream, so `issue_ready` stays high for successive multiply offers.
- R4: A divide returns the signed quotient truncated toward zero. The most negative operand divided by -1 returns the most negative value, 0x80000000.
- R5: A divide by zero returns 0xFFFFFFFF.
- R6: A divide taken in cycle N produces its result in cycle N+DIV_LAT and raises exactly one result.
- R7: After a divide is taken, `issue_ready` is low for a divide offer for exactly DIV_LAT cycles.
- R8: While the divide engine is occupied, `issue_ready` stays high for multiply offers, and those multiplies keep the timing of R2.
- R9: When a divide result and a multiply result fall due in the same cycle, the divide result appears first. The multiply result appears one cycle later, and `issue_ready` is low for a multiply offer in the cycle of the collision.
- R10: Every result carries on `res_tag` the tag given with its operation.
- R11: After reset, `res_valid` is low and `issue_ready` is high for both operation types.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | An operation is offered |
| issue_op | input | 1 | Operation select: 0 multiply, 1 divide |
| issue_a | input | DATA_W | First operand (multiplicand or dividend) |
| issue_b | input | DATA_W | Second operand (multiplier or divisor) |
| issue_tag | input | TAG_W | Destination tag of the offered operation |
| issue_ready | output | 1 | The offered operation type can be taken this cycle |
| res_valid | output | 1 | A result is on the port this cycle |
| res_tag | output | TAG_W | Destination tag of the result |
| res_data | output | DATA_W | Result value |

## Verification
A multiply taken at the edge that ends cycle N is due in cycle N+MUL_LAT. A divide is due in cycle N+DIV_LAT. A multiply whose slot is taken by a divide is due one cycle later. The bench records the cycle at which each operation was actually taken, after any wait on `issue_ready`. It stores the due cycle with the expected tag and value. The monitor checks the arrival cycle of every result against that stored number. The collision case is steered on purpose, by timing a multiply to land in the same cycle as a divide. The bench also counts how many cycles each offer waited, which tests the ready rules directly.

// File: rtl/mdu_pkg.sv
// Shared definitions for the multiply/divide unit.
package mdu_pkg;
    // Operation select carried on issue_op.
    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } mdu_op_e;
endpackage

// File: rtl/mdu_mul_pipe.sv
// Fully pipelined signed multiplier of MUL_LAT stages.
// The product is formed on entry. The later stages only carry it forward.
// Assumes: in_valid is never high while stall is high (the top gates it through
// issue_ready). A stall freezes every stage at once.
module mdu_mul_pipe #(
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 6,
    parameter int MUL_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              stall,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [DATA_W-1:0] out_data
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int LAST   = MUL_LAT - 1;

    logic [MUL_LAT-1:0] stg_v;
    logic [TAG_W-1:0]   stg_tag  [MUL_LAT];
    logic [DATA_W-1:0]  stg_data [MUL_LAT];
    logic [PROD_W-1:0]  prod_full;

    // Form the full signed product of the incoming operands.
    always_comb begin
        prod_full = PROD_W'($signed(in_a)) * PROD_W'($signed(in_b));
    end

    // Move the valid bits along the pipeline unless it is frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_v <= '0;
        end else if (!stall) begin
            stg_v[0] <= in_valid;
            for (int i = 1; i < MUL_LAT; i++) begin
                stg_v[i] <= stg_v[i-1];
            end
        end
    end

    // Move tag and data along with the valid bits. These registers need no reset.
    always_ff @(posedge clk) begin
        if (!stall) begin
            stg_tag[0]  <= in_tag;
            stg_data[0] <= prod_full[DATA_W-1:0];
            for (int i = 1; i < MUL_LAT; i++) begin
                stg_tag[i]  <= stg_tag[i-1];
                stg_data[i] <= stg_data[i-1];
            end
        end
    end

    // The last stage drives the result.
    assign out_valid = stg_v[LAST];
    assign out_tag   = stg_tag[LAST];
    assign out_data  = stg_data[LAST];

    AST_MUL_NO_ENTRY_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !in_valid);                               // R9
    AST_MUL_HOLD_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> out_valid);                               // R9
endmodule

// File: rtl/mdu_div_seq.sv
// Blocking signed divider. It holds one divide at a time for DIV_LAT cycles.
// The quotient is worked out from the operand magnitudes and truncated toward zero.
// A zero divisor gives all ones.
// Assumes: start is raised only while busy is low. done lasts one cycle,
// and busy is still high in that cycle.
module mdu_div_seq #(
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 6,
    parameter int DIV_LAT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              busy,
    output logic              done,
    output logic [TAG_W-1:0]  out_tag,
    output logic [DATA_W-1:0] out_data
);
    localparam int CNT_W = (DIV_LAT > 1) ? $clog2(DIV_LAT) : 1;

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] mag_a, mag_b, mag_q, quot;
    logic              neg_q;

    // Divide the magnitudes without sign, then put the sign back.
    always_comb begin
        mag_a = in_a[DATA_W-1] ? -in_a : in_a;
        mag_b = in_b[DATA_W-1] ? -in_b : in_b;
        neg_q = in_a[DATA_W-1] ^ in_b[DATA_W-1];
        mag_q = (mag_b == '0) ? '0 : (mag_a / mag_b);
        if (in_b == '0) quot = '1;
        else            quot = neg_q ? -mag_q : mag_q;
    end

    // Occupancy and countdown control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(DIV_LAT - 1);
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt  <= cnt - CNT_W'(1);
        end
    end

    // Capture the tag and quotient of the accepted divide.
    always_ff @(posedge clk) begin
        if (start) begin
            out_tag  <= in_tag;
            out_data <= quot;
        end
    end

    assign done = busy && (cnt == '0);

    AST_DIV_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);                                   // R7
    AST_DIV_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                    // R6
    AST_DIV_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);                          // R7
endmodule

// File: rtl/mdu_result_sel.sv
// Shared result port. A finishing divide wins. A multiply result due in the
// same cycle is held back by freezing the multiply pipeline for one cycle.
// Assumes: divide completions never come in two cycles in a row.
module mdu_result_sel #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_done,
    input  logic [TAG_W-1:0]  div_tag,
    input  logic [DATA_W-1:0] div_data,
    input  logic              mul_valid,
    input  logic [TAG_W-1:0]  mul_tag,
    input  logic [DATA_W-1:0] mul_data,
    output logic              mul_stall,
    output logic              res_valid,
    output logic [TAG_W-1:0]  res_tag,
    output logic [DATA_W-1:0] res_data
);
    // Choose the divide result whenever one is present.
    always_comb begin
        mul_stall = mul_valid && div_done;
        res_valid = mul_valid || div_done;
        res_tag   = div_done ? div_tag  : mul_tag;
        res_data  = div_done ? div_data : mul_data;
    end

    AST_HELD_MUL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        mul_stall |=> (res_valid && !div_done));            // R9
endmodule

// File: rtl/mdu_unit.sv
// Integer multiply/divide execution unit (top level).
// Routes each accepted operation to the multiply pipeline or the divide engine.
// Sets issue_ready for the operation type being offered, and merges both
// result streams onto a single port.
// Assumes: MUL_LAT >= 1, DIV_LAT >= 1. Tags are unique among operations in flight.
module mdu_unit #(
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 6,
    parameter int MUL_LAT = 3,
    parameter int DIV_LAT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic              issue_op,
    input  logic [DATA_W-1:0] issue_a,
    input  logic [DATA_W-1:0] issue_b,
    input  logic [TAG_W-1:0]  issue_tag,
    output logic              issue_ready,
    output logic              res_valid,
    output logic [TAG_W-1:0]  res_tag,
    output logic [DATA_W-1:0] res_data
);
    import mdu_pkg::*;

    logic              is_div, mul_fire, div_fire, mul_stall;
    logic              div_busy, div_done;
    logic [TAG_W-1:0]  div_tag, mul_tag;
    logic [DATA_W-1:0] div_data, mul_data;
    logic              mul_valid;

    // Ready and fire decode for the offered operation.
    always_comb begin
        is_div      = (issue_op == OP_DIV);
        issue_ready = is_div ? !div_busy : !mul_stall;
        div_fire    = issue_valid && issue_ready && is_div;
        mul_fire    = issue_valid && issue_ready && !is_div;
    end

    mdu_mul_pipe #(.DATA_W(DATA_W), .TAG_W(TAG_W), .MUL_LAT(MUL_LAT)) u_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(mul_fire), .in_a(issue_a), .in_b(issue_b),
        .in_tag(issue_tag), .stall(mul_stall), .out_valid(mul_valid),
        .out_tag(mul_tag), .out_data(mul_data)
    );

    mdu_div_seq #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DIV_LAT(DIV_LAT)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_fire), .in_a(issue_a), .in_b(issue_b),
        .in_tag(issue_tag), .busy(div_busy), .done(div_done),
        .out_tag(div_tag), .out_data(div_data)
    );

    mdu_result_sel #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .div_done(div_done), .div_tag(div_tag),
        .div_data(div_data), .mul_valid(mul_valid), .mul_tag(mul_tag),
        .mul_data(mul_data), .mul_stall(mul_stall), .res_valid(res_valid),
        .res_tag(res_tag), .res_data(res_data)
    );

    AST_MUL_OPEN_WHILE_DIV_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (div_busy && !mul_stall && issue_valid && !is_div) |-> issue_ready); // R8
endmodule

// File: tb/mdu_unit_tb.sv
// Scoreboard bench for mdu_unit.
module mdu_unit_tb;
    localparam int DATA_W  = 32;
    localparam int TAG_W   = 6;
    localparam int MUL_LAT = 3;
    localparam int DIV_LAT = 8;
    localparam int WATCHDOG = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              issue_valid = 1'b0;
    logic              issue_op = 1'b0;
    logic [DATA_W-1:0] issue_a = '0;
    logic [DATA_W-1:0] issue_b = '0;
    logic [TAG_W-1:0]  issue_tag = '0;
    logic              issue_ready;
    logic              res_valid;
    logic [TAG_W-1:0]  res_tag;
    logic [DATA_W-1:0] res_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int next_tag = 0;
    bit finished = 1'b0;

    typedef struct {
        int          tag;
        logic [31:0] data;
        int          due;
        string       req;
    } exp_t;
    exp_t sb[$];

    mdu_unit #(.DATA_W(DATA_W), .TAG_W(TAG_W), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_a(issue_a), .issue_b(issue_b), .issue_tag(issue_tag),
        .issue_ready(issue_ready), .res_valid(res_valid), .res_tag(res_tag),
        .res_data(res_data)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_mul(input logic [31:0] a, input logic [31:0] b);
        longint p;
        p = longint'($signed(a)) * longint'($signed(b));
        return p[31:0];
    endfunction

    function automatic logic [31:0] exp_div(input logic [31:0] a, input logic [31:0] b);
        longint q;
        if (b == 32'h0) return 32'hFFFF_FFFF;
        q = longint'($signed(a)) / longint'($signed(b));
        return q[31:0];
    endfunction

    // Driver: offer an operation, wait for ready, push the expected result.
    task automatic issue(input bit op, input logic [31:0] a, input logic [31:0] b,
                         input int extra, input string req, output int waits);
        int lat;
        @(negedge clk);
        issue_valid = 1'b1;
        issue_op    = op;
        issue_a     = a;
        issue_b     = b;
        issue_tag   = TAG_W'(next_tag);
        waits = 0;
        #1;
        while (!issue_ready) begin
            waits++;
            @(negedge clk);
            #1;
        end
        lat = op ? DIV_LAT : MUL_LAT;
        sb.push_back('{tag: next_tag, data: op ? exp_div(a, b) : exp_mul(a, b),
                       due: cyc + lat + extra, req: req});
        next_tag = (next_tag + 1) % (1 << TAG_W);
    endtask

    task automatic idle();
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < DIV_LAT + MUL_LAT + 4; i++) idle();
    endtask

    // Monitor: take each result off the scoreboard and compare it.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && res_valid) begin
                int idx;
                idx = -1;
                foreach (sb[i]) if (sb[i].tag == int'(res_tag) && idx < 0) idx = i;
                check(idx >= 0, "R10", "result tag matches an outstanding operation",
                      res_tag, res_tag);
                if (idx >= 0) begin
                    check(res_data == sb[idx].data, "R1/R4/R5", "result value",
                          res_data, sb[idx].data);
                    check(cyc == sb[idx].due, sb[idx].req, "result cycle",
                          cyc, sb[idx].due);
                    sb.delete(idx);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reaches the summary.
    initial begin
        wait (cyc > WATCHDOG);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int w;
        int m0;
        int target;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R11: reset state, for both operation types
        check(res_valid == 1'b0, "R11", "res_valid after reset", res_valid, 0);
        issue_op = 1'b0; #1;
        check(issue_ready == 1'b1, "R11", "ready for multiply after reset", issue_ready, 1);
        issue_op = 1'b1; #1;
        check(issue_ready == 1'b1, "R11", "ready for divide after reset", issue_ready, 1);

        // R1 R2 R3: directed multiplies back to back
        issue(0, 32'd3, 32'd4, 0, "R2", w);
        issue(0, 32'hFFFF_FFFB, 32'd7, 0, "R2", w);
        check(w == 0, "R3", "back-to-back multiply wait", w, 0);
        issue(0, 32'h7FFF_FFFF, 32'd2, 0, "R2", w);
        check(w == 0, "R3", "back-to-back multiply wait", w, 0);
        issue(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R2", w);
        issue(0, 32'h1234_5678, 32'h9ABC_DEF0, 0, "R2", w);
        issue(0, 32'h8000_0000, 32'h8000_0000, 0, "R2", w);
        // R1 R3: stream of random multiplies
        for (int i = 0; i < 40; i++) begin
            issue(0, $urandom, $urandom, 0, "R2", w);
            check(w == 0, "R3", "streamed multiply wait", w, 0);
        end
        drain();

        // R4 R5 R6: directed divides; R7 checks the wait on each later one
        issue(1, 32'd100, 32'd7, 0, "R6", w);
        issue(1, 32'hFFFF_FF9C, 32'd7, 0, "R6", w);
        check(w == DIV_LAT, "R7", "divide wait while busy", w, DIV_LAT);
        issue(1, 32'd100, 32'hFFFF_FFF9, 0, "R6", w);
        issue(1, 32'hFFFF_FF9C, 32'hFFFF_FFF9, 0, "R6", w);
        issue(1, 32'd5, 32'd0, 0, "R5", w);
        issue(1, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R4", w);
        check(w == DIV_LAT, "R7", "divide wait while busy", w, DIV_LAT);
        for (int i = 0; i < 6; i++) issue(1, $urandom, $urandom % 5000, 0, "R6", w);
        drain();

        // R8: multiplies taken while a divide is busy, far from its completion
        issue(1, 32'd77, 32'd3, 0, "R6", w);
        issue(0, 32'd9, 32'hFFFF_FFFE, 0, "R8", w);
        check(w == 0, "R8", "multiply wait while divide busy", w, 0);
        issue(0, 32'd11, 32'd13, 0, "R8", w);
        check(w == 0, "R8", "multiply wait while divide busy", w, 0);
        drain();

        // R9: a multiply timed to land in the same cycle as a divide
        issue(1, 32'd1000, 32'd10, 0, "R9", w);
        m0 = cyc;
        target = m0 + DIV_LAT - MUL_LAT;
        while (cyc + 1 < target) idle();
        issue(0, 32'd6, 32'd7, 1, "R9", w);
        check(cyc == target, "R9", "collision multiply issue cycle", cyc, target);
        while (cyc + 1 < m0 + DIV_LAT) idle();
        issue(0, 32'd2, 32'd21, 0, "R9", w);
        check(w == 1, "R9", "multiply wait in collision cycle", w, 1);
        drain();

        check(sb.size() == 0, "R2/R6", "no outstanding results", sb.size(), 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule